// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the integer execution unit of a load-store RISC core. Each cycle it takes two 32-bit operands, a 5-bit constant shift amount and a 4-bit operation code. One clock edge later it presents a 32-bit result and a flag that requests an arithmetic overflow exception. Its operations are addition and subtraction in trapping (signed) and non-trapping (unsigned) forms, the four bitwise operations AND, OR, XOR and NOR, left-logical and right-arithmetic shifts by either a constant or a register-held amount, signed and unsigned set-on-less-than, and placing a 16-bit constant in the upper half of a word.

Sign or zero extension of immediates happens upstream, so an immediate form simply arrives on `op_b`. The overflow flag never suppresses the result. The word is always presented, and the surrounding pipeline must cancel the register write and raise the exception itself. The block contains no register file, multiplier, divider or memory path.

Top module: `alu_exec`

## Requirements
- R1: While `rst_n` is low, `result_q` and `ovf_q` are zero. After reset, the result of the inputs sampled at a rising edge appears on `result_q`/`ovf_q` right after that edge.
- R2: Code 0 (add) and code 2 (subtract) give the 32-bit wrapped sum or difference `op_a - op_b`. `ovf_q` is 1 exactly when the true two's-complement result does not fit in 32 bits. The wrapped result is presented even when `ovf_q` is 1.
- R3: Code 1 (add, no trap) and code 3 (subtract, no trap) give the same wrapped value as codes 0 and 2, with `ovf_q` always 0.
- R4: Codes 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR (complement of OR) of `op_a` and `op_b`, with `ovf_q` 0.
- R5: Code 8 shifts `op_a` left logically by `shamt`, and `op_b` has no effect. Code 10 shifts it by `op_b[4:0]`, and `op_b[31:5]` and `shamt` have no effect. Vacated bits are 0.
- R6: Code 9 (amount `shamt`) and code 11 (amount `op_b[4:0]`) shift `op_a` right, filling the vacated upper bits with copies of `op_a[31]`.
- R7: Code 12 gives 1 when `op_a` is less than `op_b` as two's-complement numbers and 0 otherwise. Bits 31:1 are 0.
- R8: Code 13 gives 1 when `op_a` is less than `op_b` as unsigned numbers and 0 otherwise. Bits 31:1 are 0.
- R9: Code 14 gives `{op_b[15:0], 16'h0000}` and ignores `op_a` and `op_b[31:16]`.
- R10: Code 15 is unassigned. It gives a zero result and `ovf_q` 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 4 | Operation code (see requirements) |
| op_a | input | 32 | First operand, shifted value for shifts |
| op_b | input | 32 | Second operand or pre-extended immediate |
| shamt | input | 5 | Constant shift amount |
| result_q | output | 32 | Registered result word |
| ovf_q | output | 1 | Registered overflow exception request |

## Verification
The overflow request and the result word are produced in the same cycle, and the result must not be dropped when the flag rises. The bench provokes this with operand pairs at the signed limits, such as 0x7FFFFFFF plus 1, 0x80000000 minus 1 and 0 minus 0x80000000. It checks both that the flag is set and that the wrapped word is present on the same edge. It then repeats the same pairs with the non-trapping codes and the unassigned code, and judges the flag to be low there while the result stays the wrapped value or zero.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRA  = 4'd9,
        OP_SLLV = 4'd10,
        OP_SRAV = 4'd11,
        OP_SLT  = 4'd12,
        OP_SLTU = 4'd13,
        OP_LUI  = 4'd14
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_inv;

    // Subtraction is a + ~b + 1; the sign test uses the inverted operand.
    assign b_inv = sub ? ~b : b;
    assign sum   = a + b_inv + {{(W-1){1'b0}}, sub};
    assign ovf   = (a[W-1] == b_inv[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  y
);
    logic [W-1:0] stg [SW+1];

    assign stg[0] = val;

    // Log-depth barrel: stage i moves by 2**i when amt[i] is set.
    for (genvar i = 0; i < SW; i++) begin : g_stage
        logic [W-1:0] moved;
        assign moved = left ? (stg[i] << (2**i))
                            : W'($signed(stg[i]) >>> (2**i));
        assign stg[i+1] = amt[i] ? moved : stg[i];
    end

    assign y = stg[SW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    always_comb begin
        case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = ~(a | b);
        endcase
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         uns,
    output logic         lt
);
    assign lt = uns ? (a < b) : ($signed(a) < $signed(b));
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] result_q,
    output logic              ovf_q
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              ovf;
    } alu_state_t;

    alu_state_t state_d, state_q;
    alu_op_e    op_e;

    logic [DATA_W-1:0] as_sum, lg_y, sh_y;
    logic [SH_W-1:0]   sh_amt;
    logic              as_ovf, as_sub, sh_left, var_amt, cmp_lt;

    assign op_e    = alu_op_e'(op_sel);
    assign as_sub  = (op_e == OP_SUB) || (op_e == OP_SUBU);
    assign sh_left = (op_e == OP_SLL) || (op_e == OP_SLLV);
    assign var_amt = (op_e == OP_SLLV) || (op_e == OP_SRAV);
    assign sh_amt  = var_amt ? op_b[SH_W-1:0] : shamt;

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a(op_a), .b(op_b), .sub(as_sub), .sum(as_sum), .ovf(as_ovf)
    );

    alu_logic #(.W(DATA_W)) u_logic (
        .a(op_a), .b(op_b), .sel(op_sel[1:0]), .y(lg_y)
    );

    alu_shifter #(.W(DATA_W), .SW(SH_W)) u_shift (
        .val(op_a), .amt(sh_amt), .left(sh_left), .y(sh_y)
    );

    alu_compare #(.W(DATA_W)) u_cmp (
        .a(op_a), .b(op_b), .uns(op_e == OP_SLTU), .lt(cmp_lt)
    );

    always_comb begin
        state_d = '0;
        case (op_e)
            OP_ADD, OP_SUB: begin
                state_d.result = as_sum;
                state_d.ovf    = as_ovf;
            end
            OP_ADDU, OP_SUBU:
                state_d.result = as_sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:
                state_d.result = lg_y;
            OP_SLL, OP_SRA, OP_SLLV, OP_SRAV:
                state_d.result = sh_y;
            OP_SLT, OP_SLTU:
                state_d.result = {{(DATA_W-1){1'b0}}, cmp_lt};
            OP_LUI:
                state_d.result = {op_b[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}};
            default: state_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_q = state_q.result;
    assign ovf_q    = state_q.ovf;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_sel,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] result_q,
    input logic              ovf_q
);
    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (result_q == '0 && !ovf_q)); // R1

    AST_TRAP_ONLY_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ovf_q) |-> ($past(op_sel) == OP_ADD || $past(op_sel) == OP_SUB)); // R2

    AST_ADD_OVF_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ovf_q && $past(op_sel) == OP_ADD)
        |-> ($past(op_a[DATA_W-1]) == $past(op_b[DATA_W-1])
             && result_q[DATA_W-1] != $past(op_a[DATA_W-1]))); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ($past(op_sel) == OP_ADDU || $past(op_sel) == OP_SUBU)) |-> !ovf_q); // R3

    AST_NOR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_sel) == OP_NOR) |-> (result_q == ~($past(op_a) | $past(op_b)))); // R4

    AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ($past(op_sel) == OP_SRA || $past(op_sel) == OP_SRAV))
        |-> (result_q[DATA_W-1] == $past(op_a[DATA_W-1]))); // R6

    AST_SLT_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ($past(op_sel) == OP_SLT || $past(op_sel) == OP_SLTU))
        |-> (result_q[DATA_W-1:1] == '0)); // R7 R8

    AST_LUI_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_sel) == OP_LUI)
        |-> (result_q[DATA_W-IMM_W-1:0] == '0
             && result_q[DATA_W-1:DATA_W-IMM_W] == $past(op_b[IMM_W-1:0]))); // R9

    AST_UNASSIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && $past(op_sel) == 4'd15) |-> (result_q == '0 && !ovf_q)); // R10
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .result_q(result_q), .ovf_q(ovf_q)
);

// File: tb/alu_exec_tb.sv
module alu_exec_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYC    = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result_q;
    logic        ovf_q;

    int checks = 0;
    int errors = 0;

    alu_exec u_dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
        .shamt(shamt), .result_q(result_q), .ovf_q(ovf_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got_r, input logic got_o,
                         input logic [31:0] exp_r, input logic exp_o);
        checks++;
        if (got_r !== exp_r || got_o !== exp_o) begin
            errors++;
            $display("FAIL %s: result %h ovf %b, expected result %h ovf %b",
                     tag, got_r, got_o, exp_r, exp_o);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh,
                       input logic [31:0] exp_r, input logic exp_o);
        @(negedge clk);
        op_sel = op; op_a = a; op_b = b; shamt = sh;
        @(negedge clk);
        check(tag, result_q, ovf_q, exp_r, exp_o);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        op_sel = 4'd0; op_a = 32'h7FFF_FFFF; op_b = 32'h1;
        repeat (3) @(negedge clk);
        check("R1 reset holds zero", result_q, ovf_q, 32'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first result after reset", result_q, ovf_q, 32'h8000_0000, 1'b1);
    endtask

    task automatic t_signed();
        run("R2 add small",          4'd0, 32'd5, 32'd7, 5'd0, 32'd12, 1'b0);
        run("R2 add pos overflow",   4'd0, 32'h7FFF_FFFF, 32'h1, 5'd0, 32'h8000_0000, 1'b1);
        run("R2 add neg overflow",   4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, 32'h0, 1'b1);
        run("R2 add -1+1",           4'd0, 32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0, 1'b0);
        run("R2 sub neg overflow",   4'd2, 32'h8000_0000, 32'h1, 5'd0, 32'h7FFF_FFFF, 1'b1);
        run("R2 sub 0-min overflow", 4'd2, 32'h0, 32'h8000_0000, 5'd0, 32'h8000_0000, 1'b1);
        run("R2 sub 3-5",            4'd2, 32'd3, 32'd5, 5'd0, 32'hFFFF_FFFE, 1'b0);
        run("R2 sub -1-min no ovf",  4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 5'd0, 32'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_unsigned();
        run("R3 addu wraps no trap", 4'd1, 32'h7FFF_FFFF, 32'h1, 5'd0, 32'h8000_0000, 1'b0);
        run("R3 addu carry out",     4'd1, 32'hFFFF_FFFF, 32'h2, 5'd0, 32'h1, 1'b0);
        run("R3 subu no trap",       4'd3, 32'h8000_0000, 32'h1, 5'd0, 32'h7FFF_FFFF, 1'b0);
        run("R3 subu borrow",        4'd3, 32'h0, 32'h1, 5'd0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_logic();
        run("R4 and", 4'd4, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h00F0_1200, 1'b0);
        run("R4 or",  4'd5, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFFF0_FF34, 1'b0);
        run("R4 xor", 4'd6, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'hFF00_ED34, 1'b0);
        run("R4 nor", 4'd7, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd0, 32'h000F_00CB, 1'b0);
    endtask

    task automatic t_shift();
        run("R5 sll const ignores b", 4'd8,  32'h8000_000F, 32'hFFFF_FFFF, 5'd4, 32'h0000_00F0, 1'b0);
        run("R5 sll const 31",        4'd8,  32'h0000_0003, 32'h0, 5'd31, 32'h8000_0000, 1'b0);
        run("R5 sllv low bits only",  4'd10, 32'h0000_0101, 32'hFFFF_FFE3, 5'd9, 32'h0000_0808, 1'b0);
        run("R5 sllv zero amount",    4'd10, 32'h1234_5678, 32'h0000_0020, 5'd7, 32'h1234_5678, 1'b0);
        run("R6 sra neg fill",        4'd9,  32'h8000_0010, 32'h0, 5'd4, 32'hF800_0001, 1'b0);
        run("R6 sra pos fill",        4'd9,  32'h7000_0000, 32'h0, 5'd28, 32'h0000_0007, 1'b0);
        run("R6 srav amount 36->4",   4'd11, 32'hF000_0000, 32'd36, 5'd0, 32'hFF00_0000, 1'b0);
        run("R6 srav by 31",          4'd11, 32'h8000_0000, 32'd31, 5'd0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_compare();
        run("R7 slt -1<1",        4'd12, 32'hFFFF_FFFF, 32'h1, 5'd0, 32'h1, 1'b0);
        run("R7 slt 1<-1 false",  4'd12, 32'h1, 32'hFFFF_FFFF, 5'd0, 32'h0, 1'b0);
        run("R7 slt equal",       4'd12, 32'h8000_0000, 32'h8000_0000, 5'd0, 32'h0, 1'b0);
        run("R8 sltu big<1 false",4'd13, 32'hFFFF_FFFF, 32'h1, 5'd0, 32'h0, 1'b0);
        run("R8 sltu 1<big",      4'd13, 32'h1, 32'hFFFF_FFFF, 5'd0, 32'h1, 1'b0);
        run("R8 sltu equal",      4'd13, 32'h5, 32'h5, 5'd0, 32'h0, 1'b0);
    endtask

    task automatic t_upper_and_unassigned();
        run("R9 lui",              4'd14, 32'hDEAD_BEEF, 32'hABCD_1234, 5'd3, 32'h1234_0000, 1'b0);
        run("R9 lui all ones",     4'd14, 32'h0, 32'h0000_FFFF, 5'd0, 32'hFFFF_0000, 1'b0);
        run("R10 unassigned code", 4'd15, 32'h7FFF_FFFF, 32'h1, 5'd5, 32'h0, 1'b0);
        run("R10 after nonzero",   4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd31, 32'h0, 1'b0);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog: ran %0d cycles, expected to finish sooner", MAX_CYC);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_signed();
        t_unsigned();
        t_logic();
        t_shift();
        t_compare();
        t_upper_and_unassigned();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule